// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the six status flags of a UART-style serial port and the receive holding register behind them. The transmit and receive datapaths send it event strobes: a buffer-to-shifter transfer, a level that says the transmit shifter has nothing left to send, a received character with its noise indication, and an idle-line detection. The bus side sends read and write strobes for a status register and a data register. It also sends the transmitter-enable level and a strobe for a send-break write.

Every flag is cleared in two steps. First, a status read samples the flag. If the flag was 1 at that read, it is armed. A later data-register access then clears it: a write for the transmit-empty flag, a read for the four receive-side flags. The transmit-complete flag also clears after a preamble is queued (transmitter enable goes from 0 to 1) or after a break is queued. When a new character arrives while the previous one is still unread, the new character is dropped and an overrun is recorded. One combined interrupt request is the OR of the receive-side flags.

Top module: `uart_status_flags`

## Requirements
- R1: After reset, status_o is 8'hC0 (transmit empty and transmit complete set, all others clear), arm_o is 0 and irq_o is 0.
- R2: The transmit-empty flag (status bit 7) sets on xfer_i. It clears only on a data write that follows a status read which saw it as 1. A data write with no such read leaves it set.
- R3: The transmit-complete flag (status bit 6) clears after an armed status read on one of three actions: a data write, a 0-to-1 change of tx_en_i, or brk_wr_i. It sets again on the cycle in which transmit-empty is 1 and shift_idle_i becomes 1 after being 0.
- R4: On rx_char_i with the receive-full flag (bit 5) clear, rx_data_i is captured into data_o and receive-full sets. A data read with no armed status read leaves it set.
- R5: On rx_char_i with receive-full already set, overrun (bit 3) sets. data_o keeps the old character, and that character's noise indication is dropped.
- R6: Receive-full, idle (bit 4), overrun (bit 3) and noise (bit 2) each clear on a data read that follows a status read which saw them as 1. Noise sets together with receive-full when rx_noise_i is high, and idle sets on rx_idle_i.
- R7: status_o bits 1 and 0 always read as 0.
- R8: Each flag's arm bit (arm_o, same order as status bits 7..2) is loaded with that flag's value at every status read and is consumed by its clearing access. A flag that sets after the read is not cleared by the next access, and a later status read re-arms it.
- R9: When a flag's set event and its armed clearing access fall in the same cycle, the flag stays set.
- R10: irq_o is 1 exactly when any of receive-full, idle, overrun or noise is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| tx_en_i | input | 1 | Transmitter enable level |
| brk_wr_i | input | 1 | Write of 1 to the send-break control |
| xfer_i | input | 1 | Transmit buffer moved into the shifter |
| shift_idle_i | input | 1 | Transmitter sends no data, preamble or break |
| rx_char_i | input | 1 | Received character ready for the holding register |
| rx_noise_i | input | 1 | Noise seen in that character |
| rx_idle_i | input | 1 | Idle line detected |
| rx_data_i | input | DATA_W | Received character |
| status_o | output | 8 | Status register image |
| arm_o | output | 6 | Per-flag clear-arming state |
| data_o | output | DATA_W | Receive holding register |
| irq_o | output | 1 | Combined receive interrupt request |

## Verification
Two functions can meet in one clock: a flag's set event and the data-register access that would clear that armed flag. The bench forces this in two cases. In the first, it arms the idle flag and then pulses rx_idle_i in the same cycle as a data read. In the second, it arms transmit-empty and then drives xfer_i in the same cycle as a data write. In both cases the flag must read 1 afterwards. The companion flag cleared by the same access (receive-full, or transmit-complete) must read 0.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned STAT_W    = 8;
  // flag vector index == status bit - 2
  localparam int unsigned F_TDRE  = 5;
  localparam int unsigned F_TC    = 4;
  localparam int unsigned F_RDRF  = 3;
  localparam int unsigned F_IDLE  = 2;
  localparam int unsigned F_OVR   = 1;
  localparam int unsigned F_NOISE = 0;
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'b110000;
  localparam logic [NUM_FLAGS-1:0] RX_MASK  = 6'b001111;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_evt_i,
  input  logic stat_rd_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (arm_q && clr_evt_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else if (stat_rd_i) begin
      arm_q <= flag_q;
    end else if (clr_evt_i) begin
      arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R8
  clear_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(arm_q));
  // R8
  arm_from_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(stat_rd_i));
endmodule

// File: rtl/uart_tc_track.sv
module uart_tc_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tdre_i,
  input  logic shift_idle_i,
  input  logic tx_en_i,
  input  logic brk_wr_i,
  input  logic data_wr_i,
  output logic set_o,
  output logic clr_o
);
  logic done_now, done_q, en_q;

  assign done_now = tdre_i & shift_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      done_q <= done_now;
      en_q   <= tx_en_i;
    end
  end

  // set only on entry into the done state so a queued clear is not masked
  assign set_o = done_now & ~done_q;
  assign clr_o = data_wr_i | (tx_en_i & ~en_q) | brk_wr_i;
endmodule

// File: rtl/uart_rx_side.sv
module uart_rx_side #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_char_i,
  input  logic              rx_noise_i,
  input  logic              rx_idle_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              full_i,
  output logic              set_full_o,
  output logic              set_idle_o,
  output logic              set_ovr_o,
  output logic              set_noise_o,
  output logic [DATA_W-1:0] data_o
);
  logic              accept;
  logic [DATA_W-1:0] data_q;

  assign accept      = rx_char_i & ~full_i;
  assign set_full_o  = accept;
  assign set_ovr_o   = rx_char_i & full_i;
  assign set_noise_o = accept & rx_noise_i;
  assign set_idle_o  = rx_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= rx_data_i;
    end
  end

  assign data_o = data_q;

  // R5
  overrun_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_char_i && full_i) |=> $stable(data_q));
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stat_rd_i,
  input  logic                 data_rd_i,
  input  logic                 data_wr_i,
  input  logic                 tx_en_i,
  input  logic                 brk_wr_i,
  input  logic                 xfer_i,
  input  logic                 shift_idle_i,
  input  logic                 rx_char_i,
  input  logic                 rx_noise_i,
  input  logic                 rx_idle_i,
  input  logic [DATA_W-1:0]    rx_data_i,
  output logic [STAT_W-1:0]    status_o,
  output logic [NUM_FLAGS-1:0] arm_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v, arm_v;
  logic tc_set, tc_clr;

  uart_tc_track u_tc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tdre_i      (flag_v[F_TDRE]),
    .shift_idle_i(shift_idle_i),
    .tx_en_i     (tx_en_i),
    .brk_wr_i    (brk_wr_i),
    .data_wr_i   (data_wr_i),
    .set_o       (tc_set),
    .clr_o       (tc_clr)
  );

  uart_rx_side #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_char_i  (rx_char_i),
    .rx_noise_i (rx_noise_i),
    .rx_idle_i  (rx_idle_i),
    .rx_data_i  (rx_data_i),
    .full_i     (flag_v[F_RDRF]),
    .set_full_o (set_v[F_RDRF]),
    .set_idle_o (set_v[F_IDLE]),
    .set_ovr_o  (set_v[F_OVR]),
    .set_noise_o(set_v[F_NOISE]),
    .data_o     (data_o)
  );

  assign set_v[F_TDRE] = xfer_i;
  assign set_v[F_TC]   = tc_set;
  assign clr_v[F_TDRE] = data_wr_i;
  assign clr_v[F_TC]   = tc_clr;
  assign clr_v[F_RDRF:0] = {(F_RDRF+1){data_rd_i}};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    uart_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[g]),
      .clr_evt_i(clr_v[g]),
      .stat_rd_i(stat_rd_i),
      .flag_o   (flag_v[g]),
      .arm_o    (arm_v[g])
    );
  end

  assign status_o = {flag_v, 2'b00};
  assign arm_o    = arm_v;
  assign irq_o    = |(flag_v & RX_MASK);

  // R2
  tdre_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_v[F_TDRE]) |-> $past(data_wr_i));
  // R3
  tc_set_needs_tdre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_v[F_TC]) |-> $past(flag_v[F_TDRE] && shift_idle_i));
  // R5
  ovr_no_noise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_char_i && flag_v[F_RDRF] && !flag_v[F_NOISE]) |=> !flag_v[F_NOISE]);
  // R6
  rx_clear_by_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_v[F_RDRF]) |-> $past(data_rd_i));
endmodule

// File: tb/uart_status_flags_bench.sv
`timescale 1ns/1ps
module uart_status_flags_bench;
  localparam int unsigned DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stat_rd_i = 0, data_rd_i = 0, data_wr_i = 0, tx_en_i = 0, brk_wr_i = 0;
  logic xfer_i = 0, shift_idle_i = 1, rx_char_i = 0, rx_noise_i = 0, rx_idle_i = 0;
  logic [DW-1:0] rx_data_i = '0;
  logic [7:0]    status_o;
  logic [5:0]    arm_o;
  logic [DW-1:0] data_o;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_status_flags #(.DATA_W(DW)) u_uart_status_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i),
    .data_wr_i(data_wr_i), .tx_en_i(tx_en_i), .brk_wr_i(brk_wr_i), .xfer_i(xfer_i),
    .shift_idle_i(shift_idle_i), .rx_char_i(rx_char_i), .rx_noise_i(rx_noise_i),
    .rx_idle_i(rx_idle_i), .rx_data_i(rx_data_i), .status_o(status_o), .arm_o(arm_o),
    .data_o(data_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_stat();
    stat_rd_i = 1; tick(); stat_rd_i = 0;
  endtask
  task automatic rd_data();
    data_rd_i = 1; tick(); data_rd_i = 0;
  endtask
  task automatic wr_data();
    data_wr_i = 1; tick(); data_wr_i = 0;
  endtask
  task automatic rx(logic [DW-1:0] d, logic nz);
    rx_data_i = d; rx_noise_i = nz; rx_char_i = 1; tick(); rx_char_i = 0; rx_noise_i = 0;
  endtask
  task automatic finish_tx();
    shift_idle_i = 0; tick(); shift_idle_i = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'hC0);
    chk("R1 arm", arm_o, 6'h00);
    chk("R1 irq", irq_o, 1'b0);
    chk("R7 low bits", status_o[1:0], 2'b00);
  endtask

  task automatic t_tdre();
    wr_data();
    chk("R2 write without read", status_o, 8'hC0);
    rd_stat();
    chk("R8 arm after read", arm_o, 6'b110000);
    wr_data();
    chk("R2/R3 write clears both", status_o, 8'h00);
    chk("R8 arm consumed", arm_o, 6'h00);
    shift_idle_i = 0; xfer_i = 1; tick(); xfer_i = 0;
    chk("R2 transfer sets empty", status_o, 8'h80);
    shift_idle_i = 1; tick();
    chk("R3 complete sets on idle", status_o, 8'hC0);
  endtask

  task automatic t_tc_preamble();
    rd_stat();
    tx_en_i = 1; tick();
    chk("R3 preamble clears complete", status_o, 8'h80);
    finish_tx();
    chk("R3 complete after preamble", status_o, 8'hC0);
  endtask

  task automatic t_tc_break();
    brk_wr_i = 1; tick(); brk_wr_i = 0;
    chk("R3 break without read", status_o, 8'hC0);
    rd_stat();
    brk_wr_i = 1; tick(); brk_wr_i = 0;
    chk("R3 break clears complete", status_o, 8'h80);
    finish_tx();
    chk("R3 complete after break", status_o, 8'hC0);
  endtask

  task automatic t_rx();
    rx(8'hA5, 0);
    chk("R4 full sets", status_o, 8'hE0);
    chk("R4 data captured", data_o, 8'hA5);
    chk("R10 irq on full", irq_o, 1'b1);
    rd_data();
    chk("R4 read without status read", status_o, 8'hE0);
    rx(8'h5A, 1);
    chk("R5 overrun, no noise", status_o, 8'hE8);
    chk("R5 data kept", data_o, 8'hA5);
    rd_stat(); rd_data();
    chk("R6 full and overrun cleared", status_o, 8'hC0);
    chk("R10 irq drops", irq_o, 1'b0);
  endtask

  task automatic t_noise_idle();
    rx(8'h3C, 1);
    chk("R6 noise sets with full", status_o, 8'hE4);
    rx_idle_i = 1; tick(); rx_idle_i = 0;
    chk("R6 idle sets", status_o, 8'hF4);
    rd_stat(); rd_data();
    chk("R6 idle/noise cleared", status_o, 8'hC0);
  endtask

  task automatic t_rearm();
    rd_stat();
    chk("R8 arm zero for clear flags", arm_o[3:0], 4'h0);
    rx(8'h11, 0);
    rd_data();
    chk("R8 late flag not cleared", status_o, 8'hE0);
    rd_stat();
    chk("R8 re-armed", arm_o[3], 1'b1);
    rd_data();
    chk("R8 cleared after re-read", status_o, 8'hC0);
  endtask

  task automatic t_priority();
    rx(8'h22, 0);
    rx_idle_i = 1; tick(); rx_idle_i = 0;
    rd_stat();
    data_rd_i = 1; rx_idle_i = 1; tick(); data_rd_i = 0; rx_idle_i = 0;
    chk("R9 idle set wins over read", status_o, 8'hD0);
    rd_stat(); rd_data();
    chk("R9 idle clears later", status_o, 8'hC0);
    rd_stat();
    data_wr_i = 1; xfer_i = 1; tick(); data_wr_i = 0; xfer_i = 0;
    chk("R9 empty set wins over write", status_o, 8'h80);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(); tick();
    rst_ni = 1;
    tick();
    t_reset();
    t_tdre();
    t_tc_preamble();
    t_tc_break();
    t_rx();
    t_noise_idle();
    t_rearm();
    t_priority();
    summary();
  end
endmodule